// File: doc/BRIEF.md
# Command Buffer Fetch Sequencer

This block walks one thread's list of 64-bit commands held in memory. Software gives it a start position and a stop position in a compact 32-bit stored form. The block widens each one to a full bus address with a left shift that is fixed at build time. After a `go` pulse it fetches one command at a time over a request/response memory port. Ordinary commands are consumed and counted; they are not executed here. Two jump encodings redirect the program counter, and this is how separate buffers are chained into one stream.

The thread stops and raises `done` when the program counter reaches the stop position at a command boundary. It raises `err` and halts on an opcode it does not support, leaving the program counter on the failing command. A suspend request is honoured only between commands. While suspended, the thread accepts a new start position and a new stop position, so a producer can append work or redirect the thread before releasing it.

Top module: `cmdbuf_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err`, `susp_ack` and `mem_req` are low, `cmd_count` is 0 and `pc_out` is 0.
- R2: A stored 32-bit position becomes the bus address by shifting it left by SHIFT (default 3), giving SHIFT+32 address bits. `mem_addr` carries the full address and `pc_out` returns the program counter shifted right by SHIFT.
- R3: Only one fetch is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until `mem_rvalid`. An ordinary command, meaning bits 63:56 are below 0x80 and not 0x10, advances the program counter by 8 bytes and adds one to `cmd_count`.
- R4: A command whose bits 63:32 equal 0x10000001 loads the program counter with bits 31:0 shifted left by SHIFT. It is not counted.
- R5: A command whose bits 63:32 equal 0x10000000 adds bits 31:0, sign-extended and in bytes, to the address of that jump command. It is not counted.
- R6: When the program counter equals the stop address at a command boundary, `done` rises, `busy` falls and no further fetch is issued. A `go` with the two positions equal gives `done` with no fetch and a count of 0.
- R7: A command with bits 63:56 at 0x80 or above, or with bits 63:56 equal to 0x10 but bits 63:32 matching neither jump, raises `err`, clears `busy` and leaves the program counter on that command, uncounted.
- R8: A high `susp_req` stops the thread only at a command boundary. `susp_ack` is high only when no fetch is outstanding. While suspended, the program counter and count hold, `load_cur` and `load_end` take effect, and dropping `susp_req` resumes execution from the loaded positions.
- R9: `load_cur` and `load_end` are ignored while the thread runs and is not suspended, and `go` is ignored while `busy` is high.
- R10: `go` from idle clears `done`, `err` and `cmd_count` before the first fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted when idle |
| load_cur | input | 1 | Load the program counter from `cur_addr_in` |
| load_end | input | 1 | Load the stop position from `end_addr_in` |
| cur_addr_in | input | 32 | Start position, stored (shifted) form |
| end_addr_in | input | 32 | Stop position, stored (shifted) form |
| susp_req | input | 1 | Suspend request, level |
| susp_ack | output | 1 | Thread parked at a command boundary |
| mem_req | output | 1 | Fetch request, held until response |
| mem_addr | output | 32+SHIFT | Byte address of the command fetched |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 64 | Fetched command |
| pc_out | output | 32 | Program counter, stored form |
| busy | output | 1 | Thread running or suspended |
| done | output | 1 | Stop position reached |
| err | output | 1 | Unsupported opcode met |
| cmd_count | output | CNT_W | Ordinary commands consumed since `go` |

## Verification
Random chains of one to four buffers are built. Their links are absolute jumps to bases spread across the whole 35-bit space, or relative jumps within one region, so a wrong shift or a wrong sign extension shows up as a fetch from the wrong address. Some chains carry an injected bad opcode, which separates halting with the correct program counter from simply running on. Memory latency varies between 0 and 3 cycles to expose any sampling of the response outside its valid cycle. Directed cases cover an equal start and stop, a malformed 0x10-family word, a backward relative jump, loads issued during a run, and a suspend with reprogramming. The suspend case tells a thread that parks cleanly apart from one that drops or repeats a command.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  localparam int unsigned CMD_W       = 64;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned CMD_BYTES   = 8;
  localparam logic [31:0] HI_JUMP_ABS = 32'h1000_0001;
  localparam logic [31:0] HI_JUMP_REL = 32'h1000_0000;
  localparam logic [7:0]  OPC_JUMP    = 8'h10;

  typedef enum logic [1:0] {
    K_STEP = 2'd0,
    K_JABS = 2'd1,
    K_JREL = 2'd2,
    K_BAD  = 2'd3
  } cmd_kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_WAIT = 2'd2,
    S_SUSP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cbs_addr_widen.sv
module cbs_addr_widen #(
  parameter int unsigned SHIFT = 3,
  localparam int unsigned REG_W = cmdbuf_pkg::REG_W,
  localparam int unsigned ADDR_W = REG_W + SHIFT
) (
  input  logic [REG_W-1:0]  stored,
  output logic [ADDR_W-1:0] full
);
  generate
    if (SHIFT == 0) begin : g_flat
      assign full = stored;
    end else begin : g_shift
      assign full = {stored, {SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/cbs_cmd_decode.sv
module cbs_cmd_decode
  import cmdbuf_pkg::*;
#(
  parameter logic [7:0] OP_LIMIT = 8'h80
) (
  input  logic [CMD_W-1:0] cmd,
  output cmd_kind_t        kind,
  output logic [REG_W-1:0] arg
);
  logic [31:0] hi;
  logic [7:0]  opc;

  assign hi  = cmd[63:32];
  assign opc = cmd[63:56];
  assign arg = cmd[31:0];

  always_comb begin
    if (hi == HI_JUMP_ABS)        kind = K_JABS;
    else if (hi == HI_JUMP_REL)   kind = K_JREL;
    else if (opc == OPC_JUMP)     kind = K_BAD;
    else if (opc >= OP_LIMIT)     kind = K_BAD;
    else                          kind = K_STEP;
  end
endmodule

// File: rtl/cbs_seq_ctrl.sv
module cbs_seq_ctrl
  import cmdbuf_pkg::*;
#(
  parameter int unsigned SHIFT = 3,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned ADDR_W = REG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              load_cur,
  input  logic              load_end,
  input  logic [ADDR_W-1:0] cur_full,
  input  logic [ADDR_W-1:0] end_full,
  input  logic [ADDR_W-1:0] jmp_full,
  input  logic              susp_req,
  input  logic              mem_rvalid,
  input  cmd_kind_t         kind,
  input  logic [REG_W-1:0]  arg,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc_full,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              susp_ack,
  output logic [CNT_W-1:0]  cmd_count
);
  seq_state_t        state_q;
  logic [ADDR_W-1:0] end_q;
  logic [ADDR_W-1:0] rel_off;
  logic              load_ok;

  assign rel_off = ADDR_W'($signed(arg));
  assign load_ok = (state_q == S_IDLE) || (state_q == S_SUSP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      pc_full   <= '0;
      end_q     <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      susp_ack  <= 1'b0;
      cmd_count <= '0;
    end else begin
      if (load_ok && load_cur) pc_full <= cur_full;
      if (load_ok && load_end) end_q   <= end_full;
      unique case (state_q)
        S_IDLE: begin
          if (go) begin
            state_q   <= S_RUN;
            busy      <= 1'b1;
            done      <= 1'b0;
            err       <= 1'b0;
            cmd_count <= '0;
          end
        end
        S_RUN: begin
          if (pc_full == end_q) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= S_IDLE;
          end else if (susp_req) begin
            susp_ack <= 1'b1;
            state_q  <= S_SUSP;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= pc_full;
            state_q  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            mem_req <= 1'b0;
            state_q <= S_RUN;
            unique case (kind)
              K_STEP: begin
                pc_full   <= pc_full + ADDR_W'(CMD_BYTES);
                cmd_count <= cmd_count + 1'b1;
              end
              K_JABS: pc_full <= jmp_full;
              K_JREL: pc_full <= pc_full + rel_off;
              K_BAD: begin
                err     <= 1'b1;
                busy    <= 1'b0;
                state_q <= S_IDLE;
              end
            endcase
          end
        end
        S_SUSP: begin
          if (!susp_req) begin
            susp_ack <= 1'b0;
            state_q  <= S_RUN;
          end
        end
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R8
  ack_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    susp_ack |-> !mem_req);

  // R8
  susp_hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (susp_ack && $past(susp_ack) && !$past(load_cur)) |-> $stable(pc_full));

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (pc_full == end_q && !busy));

  // R7
  err_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($stable(pc_full) && $stable(cmd_count)));

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cmd_count == $past(cmd_count) || cmd_count == $past(cmd_count) + 1'b1));
endmodule

// File: rtl/cmdbuf_seq.sv
module cmdbuf_seq
  import cmdbuf_pkg::*;
#(
  parameter int unsigned SHIFT    = 3,
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  OP_LIMIT = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic                   load_cur,
  input  logic                   load_end,
  input  logic [31:0]            cur_addr_in,
  input  logic [31:0]            end_addr_in,
  input  logic                   susp_req,
  output logic                   susp_ack,
  output logic                   mem_req,
  output logic [32+SHIFT-1:0]    mem_addr,
  input  logic                   mem_rvalid,
  input  logic [63:0]            mem_rdata,
  output logic [31:0]            pc_out,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [CNT_W-1:0]       cmd_count
);
  localparam int unsigned ADDR_W = REG_W + SHIFT;
  localparam int unsigned N_WIDE = 3;

  cmd_kind_t         kind;
  logic [REG_W-1:0]  arg;
  logic [REG_W-1:0]  stored_in [N_WIDE];
  logic [ADDR_W-1:0] full_out  [N_WIDE];
  logic [ADDR_W-1:0] pc_full;

  assign stored_in[0] = cur_addr_in;
  assign stored_in[1] = end_addr_in;
  assign stored_in[2] = arg;

  generate
    for (genvar i = 0; i < N_WIDE; i++) begin : g_widen
      cbs_addr_widen #(.SHIFT(SHIFT)) u_widen (
        .stored (stored_in[i]),
        .full   (full_out[i])
      );
    end
  endgenerate

  cbs_cmd_decode #(.OP_LIMIT(OP_LIMIT)) u_decode (
    .cmd  (mem_rdata),
    .kind (kind),
    .arg  (arg)
  );

  cbs_seq_ctrl #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .load_cur   (load_cur),
    .load_end   (load_end),
    .cur_full   (full_out[0]),
    .end_full   (full_out[1]),
    .jmp_full   (full_out[2]),
    .susp_req   (susp_req),
    .mem_rvalid (mem_rvalid),
    .kind       (kind),
    .arg        (arg),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .pc_full    (pc_full),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .susp_ack   (susp_ack),
    .cmd_count  (cmd_count)
  );

  assign pc_out = pc_full[ADDR_W-1:SHIFT];
endmodule

// File: tb/cmdbuf_seq_tb.sv
`timescale 1ns/1ps
module cmdbuf_seq_tb;
  localparam int SH = 3;
  localparam int AW = 32 + SH;
  localparam logic [31:0] ABS = 32'h1000_0001;
  localparam logic [31:0] REL = 32'h1000_0000;

  logic clk = 0, rst = 1, go = 0, load_cur = 0, load_end = 0, susp_req = 0;
  logic [31:0] cur_addr_in = 0, end_addr_in = 0;
  logic susp_ack, mem_req, mem_rvalid = 0, busy, done, err;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_rdata = 0;
  logic [31:0] pc_out;
  logic [15:0] cmd_count;

  int checks = 0, errors = 0, nreq = 0, wcnt = 0;
  bit finished = 0, prev_req = 0;
  logic [AW-1:0] first_addr;
  logic [63:0] mem [logic [AW-1:0]];

  cmdbuf_seq u_dut (
    .clk(clk), .rst(rst), .go(go), .load_cur(load_cur), .load_end(load_end),
    .cur_addr_in(cur_addr_in), .end_addr_in(end_addr_in), .susp_req(susp_req),
    .susp_ack(susp_ack), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .busy(busy), .done(done), .err(err), .cmd_count(cmd_count)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] rd(input logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  // memory responder and request monitor, both on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !prev_req) begin
        if (nreq == 0) first_addr = mem_addr;
        nreq++;
      end
      prev_req = mem_req;
      if (mem_rvalid) mem_rvalid = 0;
      else if (mem_req) begin
        if (wcnt == 0) begin
          mem_rvalid = 1;
          mem_rdata  = rd(mem_addr);
          wcnt = $urandom % 4;
        end else wcnt--;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // independent reference walk
  function automatic void model(input logic [AW-1:0] s, input logic [AW-1:0] e,
                                output logic [AW-1:0] pf, output int cnt,
                                output bit er, output bit dn);
    logic [AW-1:0] p = s;
    cnt = 0; er = 0; dn = 0;
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] w;
      if (p == e) begin dn = 1; break; end
      w = rd(p);
      if (w[63:32] == ABS) p = {w[31:0], 3'b000};
      else if (w[63:32] == REL) p = p + {{SH{w[31]}}, w[31:0]};
      else if (w[63:56] == 8'h10 || w[63:56] >= 8'h80) begin er = 1; break; end
      else begin p = p + 8; cnt++; end
    end
    pf = p;
  endfunction

  task automatic load(input logic [AW-1:0] c, input logic [AW-1:0] e);
    @(negedge clk);
    cur_addr_in = c[AW-1:SH]; end_addr_in = e[AW-1:SH];
    load_cur = 1; load_end = 1;
    @(negedge clk);
    load_cur = 0; load_end = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic wait_stop();
    for (int k = 0; k < 20000; k++) begin
      if (!busy && (done || err)) break;
      @(negedge clk);
    end
  endtask

  task automatic run_cmp(input logic [AW-1:0] s, input logic [AW-1:0] e, input string req);
    logic [AW-1:0] pf; int cnt; bit er, dn;
    model(s, e, pf, cnt, er, dn);
    load(s, e);
    nreq = 0;
    pulse_go();
    wait_stop();
    chk(pc_out == pf[AW-1:SH], req, "pc", pc_out, pf[AW-1:SH]);
    chk(cmd_count == 16'(cnt), req, "count", cmd_count, cnt);
    chk(done == dn && err == er, req, "done/err", {done, err}, {dn, er});
  endtask

  function automatic logic [63:0] nop();
    logic [7:0] o;
    do o = 8'($urandom % 128); while (o == 8'h10);
    return {o, 24'($urandom), 32'($urandom)};
  endfunction

  initial begin
    logic [AW-1:0] b, e2, bases[4];
    int lens[4];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !susp_ack && !mem_req, "R1", "flags",
        {busy, done, err, susp_ack, mem_req}, 0);
    chk(cmd_count == 0 && pc_out == 0, "R1", "count/pc", {cmd_count, pc_out}, 0);

    // R2 stored form readback and high address fetch
    mem.delete();
    b = 35'h7_8000_0040;
    mem[b] = nop();
    load(b, b + 8);
    chk(pc_out == b[AW-1:SH], "R2", "pc readback", pc_out, b[AW-1:SH]);
    nreq = 0;
    pulse_go(); wait_stop();
    chk(first_addr == b, "R2", "mem_addr", first_addr, b);
    chk(done && cmd_count == 1, "R3", "single step", {done, cmd_count}, {1'b1, 16'd1});

    // R6 equal positions: done, zero fetches
    load(35'h100, 35'h100);
    nreq = 0;
    pulse_go(); wait_stop();
    chk(done && nreq == 0 && cmd_count == 0, "R6", "empty run", {done, 32'(nreq)}, {1'b1, 32'd0});

    // R7 malformed jump-family word after two steps; R10 go clears err later
    mem.delete();
    mem[35'h200] = nop(); mem[35'h208] = nop();
    mem[35'h210] = {32'h1000_0002, 32'h0};
    run_cmp(35'h200, 35'h400, "R7");
    chk(err && pc_out == 32'h42, "R7", "halt pc", pc_out, 32'h42);

    // R5 backward relative jump then absolute forward; R10 flags cleared
    mem.delete();
    mem[35'h1000] = {REL, 32'hFFFF_FF00};
    mem[35'h0F00] = nop();
    mem[35'h0F08] = {ABS, 32'h0000_0400};
    mem[35'h2000] = nop();
    run_cmp(35'h1000, 35'h2008, "R5");
    chk(!err && done, "R10", "err cleared by go", {done, err}, 2'b10);

    // R9 loads and go during a run are ignored
    mem.delete();
    for (int j = 0; j < 12; j++) mem[35'h3000 + 35'(8*j)] = nop();
    load(35'h3000, 35'h3060);
    pulse_go();
    repeat (5) @(negedge clk);
    cur_addr_in = 32'h123; end_addr_in = 32'h456; load_cur = 1; load_end = 1; go = 1;
    @(negedge clk);
    load_cur = 0; load_end = 0; go = 0;
    wait_stop();
    chk(done && pc_out == 32'h60C && cmd_count == 12, "R9", "loads ignored",
        {pc_out, cmd_count}, {32'h60C, 16'd12});

    // R8 suspend, reprogram, resume
    mem.delete();
    for (int j = 0; j < 20; j++) mem[35'h4000 + 35'(8*j)] = nop();
    for (int j = 0; j < 3; j++) mem[35'h5000 + 35'(8*j)] = nop();
    load(35'h4000, 35'h40A0);
    pulse_go();
    repeat (10) @(negedge clk);
    susp_req = 1;
    for (int k = 0; k < 50 && !susp_ack; k++) @(negedge clk);
    chk(susp_ack && !mem_req && busy, "R8", "parked", {susp_ack, mem_req}, 2'b10);
    begin
      logic [31:0] p0; logic [15:0] c0;
      p0 = pc_out; c0 = cmd_count;
      repeat (3) @(negedge clk);
      chk(pc_out == p0 && cmd_count == c0, "R8", "held", pc_out, p0);
      load(35'h5000, 35'h5018);
      chk(pc_out == 32'hA00, "R8", "load while parked", pc_out, 32'hA00);
      susp_req = 0;
      wait_stop();
      chk(done && pc_out == 32'hA03 && cmd_count == c0 + 3, "R8", "resumed",
          cmd_count, c0 + 3);
    end

    // R3 R4 R5 R7 random chains
    for (int t = 0; t < 60; t++) begin
      bit rel, inj;
      int nb;
      logic [AW-1:0] hib;
      mem.delete();
      nb = 1 + $urandom % 4;
      rel = $urandom % 2;
      inj = ($urandom % 5) == 0;
      hib = {19'($urandom), 16'h0};
      for (int i = 0; i < nb; i++) begin
        if (!rel) hib = {19'($urandom), 16'h0};
        bases[i] = hib | 35'(i << 12) | 35'h100;
        lens[i]  = 1 + $urandom % 8;
      end
      for (int i = 0; i < nb; i++) begin
        for (int j = 0; j < lens[i]; j++) mem[bases[i] + 35'(8*j)] = nop();
        e2 = bases[i] + 35'(8*lens[i]);
        if (i < nb - 1) begin
          if (rel) mem[e2] = {REL, 32'(bases[i+1] - e2)};
          else     mem[e2] = {ABS, bases[i+1][AW-1:SH]};
        end
      end
      if (inj) mem[bases[0] + 35'(8*($urandom % lens[0]))] = {8'h80 | 8'($urandom), 56'($urandom)};
      run_cmp(bases[0], e2, rel ? "R5" : "R4");
    end
    summary();
  end
endmodule